// File: doc/BRIEF.md
# Lower-Arm Fault Protection Controller

This block guards the three low-side switches of a three-phase inverter bridge. It watches three digital comparator flags: over-current, short-circuit, and a control-supply under-voltage comparator with separate trip and clear outputs. It sits between the controller's active-low low-side drive commands and the gate drivers. Every raw flag must stay high for a parameterized number of clock cycles before it counts as a fault. A confirmed fault forces every low-side output off and drives an active-low fault line.

A current fault (over-current or short-circuit) produces a fault pulse of fixed length. The pulse timer does not restart while a pulse is running. When the pulse ends, each low-side phase stays blocked until its own command has been seen at the off level. An under-voltage fault keeps the fault line low and the low side off until the clear flag arrives. The high-side commands pass through untouched in every state.

Top module: `lafp_ctrl`

## Requirements
- R1: After reset the fault output is high (1) and each low-side output equals its command.
- R2: With no fault active, each low-side output `lo_drv_n[i]` equals `lo_cmd_n[i]` (0 = switch on, 1 = off) in the same cycle. An output is never 0 while its command is 1.
- R3: `hi_drv_n` equals `hi_cmd_n` at all times, including during any fault.
- R4: `oc_flag` held high for fewer than OC_QUAL consecutive sampling edges has no effect. When it is held for OC_QUAL edges, the fault line goes low and all low-side outputs go to 1 from the next clock edge onward.
- R5: `sc_flag` behaves as in R4 with its own delay, SC_QUAL.
- R6: A current fault holds `fault_n` low for exactly PULSE_LEN cycles. Further current faults confirmed during the pulse neither extend nor restart it.
- R7: After the pulse, phase i stays at output 1 until a clock edge samples `lo_cmd_n[i]` = 1. From then on it follows its command. Phases are released independently.
- R8: `uv_trip` held for UV_QUAL consecutive edges sets an under-voltage fault from the next edge: `fault_n` = 0 and all low-side outputs are 1. The fault lasts until an edge samples `uv_clear` = 1 while the qualified trip is low. A qualified trip takes priority over a clear.
- R9: `uv_trip` held for fewer than UV_QUAL consecutive edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Raw over-current comparator flag |
| sc_flag | input | 1 | Raw short-circuit comparator flag |
| uv_trip | input | 1 | Raw under-voltage trip comparator flag |
| uv_clear | input | 1 | Under-voltage recovery comparator flag |
| lo_cmd_n | input | NPH | Low-side commands, active low |
| hi_cmd_n | input | NPH | High-side commands, active low |
| lo_drv_n | output | NPH | Gated low-side drive, active low |
| hi_drv_n | output | NPH | High-side drive, passed through |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The hardest situation to reach is the per-phase release after a current-fault pulse. The pulse has to run to its end while the commands are held on. A second fault has to be confirmed in the middle of the pulse. Then the phases have to be turned off one at a time, so that one phase is running again while the others are still blocked. The stimulus trips an over-current with all phases commanded on and raises a short-circuit halfway through the pulse. It then turns phase 0 off and back on before releasing the other two phases. A second sequence raises the under-voltage clear while the trip is still qualified, to check that the trip wins.

// File: rtl/lafp_pkg.sv
package lafp_pkg;
   typedef enum logic [1:0] {
      CF_IDLE  = 2'd0,
      CF_PULSE = 2'd1,
      CF_HOLD  = 2'd2
   } cf_state_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lafp_qual.sv
module lafp_qual #(
   parameter int QUAL = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   output logic qual_o
);
   generate
      if (QUAL == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) qual_o <= 1'b0;
            else        qual_o <= flag_i;
         end
      end else begin : g_count
         localparam int CW = lafp_pkg::cnt_width(QUAL);
         localparam logic [CW-1:0] LAST = CW'(QUAL - 1);
         logic [CW-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
               qual_o  <= 1'b0;
            end else if (!flag_i) begin
               run_cnt <= '0;
               qual_o  <= 1'b0;
            end else if (run_cnt == LAST) begin
               qual_o  <= 1'b1;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lafp_cur_fault.sv
module lafp_cur_fault #(
   parameter int NPH       = 3,
   parameter int PULSE_LEN = 225000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trip_i,
   input  logic [NPH-1:0] lo_cmd_n,
   output logic           pulse_o,
   output logic [NPH-1:0] blk_o
);
   import lafp_pkg::*;
   localparam int TW = cnt_width(PULSE_LEN);
   localparam logic [TW-1:0] TLAST = TW'(PULSE_LEN - 1);

   cf_state_t     state;
   logic [TW-1:0] timer;
   logic [NPH-1:0] blk_next;

   always_comb begin
      blk_next = blk_o & ~lo_cmd_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CF_IDLE;
         timer <= '0;
         blk_o <= '0;
      end else begin
         case (state)
            CF_IDLE: begin
               if (trip_i) begin
                  state <= CF_PULSE;
                  timer <= '0;
                  blk_o <= '1;
               end
            end
            CF_PULSE: begin
               if (timer == TLAST) begin
                  state <= CF_HOLD;
                  timer <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            CF_HOLD: begin
               blk_o <= blk_next;
               if (blk_next == '0) state <= CF_IDLE;
            end
            default: begin
               state <= CF_IDLE;
               blk_o <= '0;
            end
         endcase
      end
   end

   assign pulse_o = (state == CF_PULSE);
endmodule

// File: rtl/lafp_uv_mon.sv
module lafp_uv_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_q_i,
   input  logic clear_i,
   output logic uv_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        uv_o <= 1'b0;
      else if (trip_q_i) uv_o <= 1'b1;
      else if (clear_i)  uv_o <= 1'b0;
   end
endmodule

// File: rtl/lafp_ctrl.sv
module lafp_ctrl #(
   parameter int NPH       = 3,
   parameter int OC_QUAL   = 1250,
   parameter int SC_QUAL   = 250,
   parameter int UV_QUAL   = 1250,
   parameter int PULSE_LEN = 225000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           oc_flag,
   input  logic           sc_flag,
   input  logic           uv_trip,
   input  logic           uv_clear,
   input  logic [NPH-1:0] lo_cmd_n,
   input  logic [NPH-1:0] hi_cmd_n,
   output logic [NPH-1:0] lo_drv_n,
   output logic [NPH-1:0] hi_drv_n,
   output logic           fault_n
);
   generate
      if (NPH < 1) begin : g_bad_nph
         $error("lafp_ctrl: NPH must be at least 1");
      end
      if (OC_QUAL < 1 || SC_QUAL < 1 || UV_QUAL < 1) begin : g_bad_qual
         $error("lafp_ctrl: qualification delays must be at least 1");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("lafp_ctrl: PULSE_LEN must be at least 1");
      end
   endgenerate

   logic oc_q, sc_q, uv_q;
   logic cur_trip, cur_pulse, uv_act;
   logic [NPH-1:0] cur_blk;

   lafp_qual #(.QUAL(OC_QUAL)) u_oc_qual (
      .clk(clk), .rst_n(rst_n), .flag_i(oc_flag), .qual_o(oc_q));
   lafp_qual #(.QUAL(SC_QUAL)) u_sc_qual (
      .clk(clk), .rst_n(rst_n), .flag_i(sc_flag), .qual_o(sc_q));
   lafp_qual #(.QUAL(UV_QUAL)) u_uv_qual (
      .clk(clk), .rst_n(rst_n), .flag_i(uv_trip), .qual_o(uv_q));

   // Short-circuit and over-current lead to the same response.
   assign cur_trip = sc_q | oc_q;

   lafp_cur_fault #(.NPH(NPH), .PULSE_LEN(PULSE_LEN)) u_cur (
      .clk(clk), .rst_n(rst_n), .trip_i(cur_trip), .lo_cmd_n(lo_cmd_n),
      .pulse_o(cur_pulse), .blk_o(cur_blk));

   lafp_uv_mon u_uv (
      .clk(clk), .rst_n(rst_n), .trip_q_i(uv_q), .clear_i(uv_clear),
      .uv_o(uv_act));

   genvar gi;
   generate
      for (gi = 0; gi < NPH; gi++) begin : g_phase
         assign lo_drv_n[gi] = lo_cmd_n[gi] | cur_blk[gi] | uv_act;
      end
   endgenerate

   assign hi_drv_n = hi_cmd_n;
   assign fault_n  = ~(cur_pulse | uv_act);
endmodule

// File: rtl/lafp_ctrl_chk.sv
module lafp_ctrl_chk #(
   parameter int NPH       = 3,
   parameter int PULSE_LEN = 225000
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NPH-1:0] lo_cmd_n,
   input logic [NPH-1:0] lo_drv_n,
   input logic           fault_n,
   input logic           cur_trip,
   input logic           cur_pulse,
   input logic [NPH-1:0] cur_blk
);
   int unsigned pulse_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pulse_cnt <= 0;
      else if (cur_pulse)  pulse_cnt <= pulse_cnt + 1;
      else                 pulse_cnt <= 0;
   end

   // R2
   drv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_cmd_n & ~lo_drv_n) == '0);

   // R4
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> (lo_drv_n == '1));

   // R6
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= PULSE_LEN);

   // R5
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cur_pulse) |-> $past(cur_trip));

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(cur_blk) & ~cur_blk) & ~$past(lo_cmd_n)) == '0);
endmodule

bind lafp_ctrl lafp_ctrl_chk #(.NPH(NPH), .PULSE_LEN(PULSE_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .lo_cmd_n(lo_cmd_n), .lo_drv_n(lo_drv_n),
   .fault_n(fault_n), .cur_trip(cur_trip), .cur_pulse(cur_pulse),
   .cur_blk(cur_blk));

// File: tb/lafp_ctrl_tb.sv
module lafp_ctrl_tb;
   localparam int NPH = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oc_flag = 1'b0, sc_flag = 1'b0, uv_trip = 1'b0, uv_clear = 1'b0;
   logic [NPH-1:0] lo_cmd_n = '1, hi_cmd_n = '1;
   logic [NPH-1:0] lo_drv_n, hi_drv_n;
   logic fault_n;

   always #4 clk = ~clk;

   lafp_ctrl #(.NPH(NPH), .OC_QUAL(8), .SC_QUAL(3), .UV_QUAL(6),
               .PULSE_LEN(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .sc_flag(sc_flag),
      .uv_trip(uv_trip), .uv_clear(uv_clear), .lo_cmd_n(lo_cmd_n),
      .hi_cmd_n(hi_cmd_n), .lo_drv_n(lo_drv_n), .hi_drv_n(hi_drv_n),
      .fault_n(fault_n));

   typedef struct {
      int             cyc;
      logic           f;
      logic [NPH-1:0] drv;
      logic [NPH-1:0] hi;
      string          tag;
   } exp_t;

   exp_t q[$];
   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(input int off, input logic f,
                            input logic [NPH-1:0] d, input string tag);
      exp_t e;
      e.cyc = cyc + off; e.f = f; e.drv = d; e.hi = hi_cmd_n; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic expect_span(input int a, input int b, input logic f,
                              input logic [NPH-1:0] d, input string tag);
      for (int k = a; k <= b; k++) expect_at(k, f, d, tag);
   endtask

   // Monitor: pops expectations whose cycle has arrived and compares.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (fault_n !== e.f || lo_drv_n !== e.drv || hi_drv_n !== e.hi) begin
               bad++;
               $display("FAIL %s cyc=%0d: fault_n=%b lo_drv_n=%b hi_drv_n=%b expected %b %b %b",
                        e.tag, cyc, fault_n, lo_drv_n, hi_drv_n, e.f, e.drv, e.hi);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1 reset state
      expect_at(0, 1'b1, 3'b111, "R1");
      tick(1);
      rst_n = 1'b1;
      expect_span(0, 2, 1'b1, 3'b111, "R1");
      tick(3);

      // R2 / R3 pass-through
      lo_cmd_n = 3'b010; hi_cmd_n = 3'b101;
      expect_span(0, 2, 1'b1, 3'b010, "R2/R3");
      tick(3);

      // R4 short over-current pulse: no effect
      oc_flag = 1'b1;
      expect_span(0, 10, 1'b1, 3'b010, "R4 short");
      tick(7);
      oc_flag = 1'b0;
      tick(4);

      // R4 trip, R6 pulse with SC inside, R7 per-phase release
      lo_cmd_n = 3'b000; oc_flag = 1'b1;
      expect_span(0, 8, 1'b1, 3'b000, "R4 qual");
      expect_span(9, 28, 1'b0, 3'b111, "R6/R3 pulse");
      expect_span(29, 31, 1'b1, 3'b111, "R7 blocked");
      tick(12);
      oc_flag = 1'b0; sc_flag = 1'b1;
      tick(8);
      sc_flag = 1'b0;
      tick(12);
      lo_cmd_n = 3'b001;
      expect_at(0, 1'b1, 3'b111, "R7");
      tick(1);
      lo_cmd_n = 3'b000;
      expect_span(0, 1, 1'b1, 3'b110, "R7 phase0 free");
      tick(2);
      lo_cmd_n = 3'b110;
      expect_at(0, 1'b1, 3'b110, "R7");
      tick(1);
      lo_cmd_n = 3'b000;
      expect_span(0, 2, 1'b1, 3'b000, "R7 all free");
      tick(3);

      // R5 short short-circuit, then trip
      sc_flag = 1'b1;
      expect_span(0, 6, 1'b1, 3'b000, "R5 short");
      tick(2);
      sc_flag = 1'b0;
      tick(5);
      sc_flag = 1'b1;
      expect_span(0, 3, 1'b1, 3'b000, "R5 qual");
      expect_span(4, 23, 1'b0, 3'b111, "R6 pulse");
      expect_at(24, 1'b1, 3'b111, "R7 blocked");
      tick(5);
      sc_flag = 1'b0;
      tick(20);
      lo_cmd_n = 3'b111;
      expect_at(0, 1'b1, 3'b111, "R7");
      tick(1);
      lo_cmd_n = 3'b000;
      expect_span(0, 1, 1'b1, 3'b000, "R7");
      tick(2);

      // R9 short under-voltage
      uv_trip = 1'b1;
      expect_span(0, 8, 1'b1, 3'b000, "R9");
      tick(5);
      uv_trip = 1'b0;
      tick(4);

      // R8 under-voltage hold and clear
      uv_trip = 1'b1;
      expect_span(0, 6, 1'b1, 3'b000, "R8 qual");
      expect_span(7, 20, 1'b0, 3'b111, "R8/R3 hold");
      expect_span(21, 22, 1'b1, 3'b000, "R8 cleared");
      tick(10);
      uv_trip = 1'b0;
      tick(10);
      uv_clear = 1'b1;
      tick(1);
      uv_clear = 1'b0;
      tick(2);

      // R8 trip beats clear
      uv_trip = 1'b1;
      expect_span(0, 6, 1'b1, 3'b000, "R8 qual");
      expect_span(7, 13, 1'b0, 3'b111, "R8 priority");
      expect_span(14, 15, 1'b1, 3'b000, "R8 released");
      tick(8);
      uv_clear = 1'b1;
      tick(4);
      uv_trip = 1'b0;
      tick(2);
      uv_clear = 1'b0;

      wait (q.size() == 0);
      tick(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule